// File: doc/BRIEF.md
# SPI Interrupt and Soft-Reset Register Block

This block sits beside an SPI shift engine and turns the engine's seven event lines into latched interrupt status. A software agent reaches it through a plain register port: a write strobe with address and data, and a read data bus that follows the address with no delay. Each source has its own enable bit. A global enable gates the single interrupt line. Status bits are cleared by writing ones back to them, so the value just read can be written back to acknowledge it.

A separate register resets the attached core on request. A write of the key value 0x0A starts a reset window of fixed length. The window drives a reset output to the core and returns every register of this block to zero. Any other value written there is dropped.

Top module: `spi_irq_regs`

## Requirements
- R1: After rst_ni deasserts, reads of offsets 0x1C, 0x20 and 0x28 return zero, and irq_o and core_rst_o are low.
- R2: A status bit sets on the clock edge that samples a 0-to-1 change of its event input and stays set after the event falls. An event held high sets its bit only once: after a clear, the bit stays clear until the event falls and rises again.
- R3: A write to offset 0x20 clears every status bit where the written data has a one and leaves the others unchanged. A rising event in the same cycle as a clear of its own bit leaves that bit set.
- R4: The per-source enable register at offset 0x28 holds bits [6:0], which can be read back. Its bits [31:7] read as zero.
- R5: The global enable register at offset 0x1C holds only bit 31, which can be read back. All its other bits read as zero.
- R6: irq_o is high exactly when global enable bit 31 is set and at least one status bit is set together with its enable bit. With bit 31 clear, irq_o is low whatever is pending.
- R7: Status bit i is fed by evt_i[i]. The bit meanings are: 0 mode fault, 1 slave-mode fault, 2 TX empty, 3 TX underrun, 4 RX full, 5 RX overrun, 6 TX half empty.
- R8: A write of 0x0A to offset 0x40 raises core_rst_o from the next cycle for exactly RST_CYCLES cycles. The same write sets the status, enable and global enable registers to zero.
- R9: A write of any other value to offset 0x40 leaves core_rst_o low and leaves all registers unchanged.
- R10: While core_rst_o is high, register writes and event edges have no effect. An event that is still high when the window ends does not set its bit.
- R11: Reads of offset 0x40 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, no delay |
| evt_i | input | NUM_SRC | Event lines from the SPI core |
| irq_o | output | 1 | Interrupt request |
| core_rst_o | output | 1 | Reset to the attached core, high during the window |

## Verification
The bench builds the block with the default seven sources, 8-bit offsets and 32-bit data. It shortens RST_CYCLES to 5. That window is short enough to count cycle by cycle, and it is still long enough to fit a blocked register write, a blocked event pulse and an event held high across its end. The default width brings the bit-31 global enable and the unused enable bits within reach of the checks.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned OFF_GIE  = 32'h1C;
  localparam int unsigned OFF_STAT = 32'h20;
  localparam int unsigned OFF_IEN  = 32'h28;
  localparam int unsigned OFF_SRST = 32'h40;
  localparam int unsigned SRST_KEY = 32'h0A;
  localparam int unsigned GIE_BIT  = 31;

  typedef enum logic [2:0] {
    SRC_MODE_FAULT  = 3'd0,
    SRC_SLAVE_FAULT = 3'd1,
    SRC_TX_EMPTY    = 3'd2,
    SRC_TX_UNDERRUN = 3'd3,
    SRC_RX_FULL     = 3'd4,
    SRC_RX_OVERRUN  = 3'd5,
    SRC_TX_HALF     = 3'd6
  } irq_src_e;
endpackage

// File: rtl/spi_irq_src_cell.sv
module spi_irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic stat_o
);
  logic prev_q;
  logic stat_q;
  logic rise;

  assign rise = evt_i & ~prev_q;

  // edge history keeps tracking during hold so a level held high across it cannot latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= 1'b0;
    else if (hold_i) stat_q <= 1'b0;
    else if (rise)   stat_q <= 1'b1;
    else if (clr_i)  stat_q <= 1'b0;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/spi_irq_soft_rst.sv
module spi_irq_soft_rst #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (fire_i)          cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 7,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic              irq_o,
  output logic              core_rst_o
);
  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFF_SRST);
  localparam int unsigned GIE_POS = (GIE_BIT < DATA_W) ? GIE_BIT : DATA_W - 1;

  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] ien_q;
  logic               gie_q;
  logic               busy;
  logic               fire;
  logic               hold;
  logic               wr_ok;

  assign wr_ok = reg_we_i & ~busy;
  assign fire  = wr_ok & (reg_addr_i == A_SRST) & (reg_wdata_i == DATA_W'(SRST_KEY));
  assign hold  = fire | busy;

  spi_irq_soft_rst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .busy_o (busy)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    spi_irq_src_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[g]),
      .clr_i  (wr_ok & (reg_addr_i == A_STAT) & reg_wdata_i[g]),
      .hold_i (hold),
      .stat_o (stat_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      gie_q <= 1'b0;
    end else if (hold) begin
      ien_q <= '0;
      gie_q <= 1'b0;
    end else if (wr_ok) begin
      if (reg_addr_i == A_IEN) ien_q <= reg_wdata_i[NUM_SRC-1:0];
      if (reg_addr_i == A_GIE) gie_q <= reg_wdata_i[GIE_POS];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_GIE:   reg_rdata_o[GIE_POS] = gie_q;
      A_STAT:  reg_rdata_o[NUM_SRC-1:0] = stat_q;
      A_IEN:   reg_rdata_o[NUM_SRC-1:0] = ien_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o      = gie_q & |(stat_q & ien_q);
  assign core_rst_o = busy;
endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk
  import spi_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 7,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_CYCLES = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               irq_o,
  input logic               core_rst_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] ien_q,
  input logic               gie_q
);
  logic key_wr;
  logic stat_wr;
  int unsigned win_cnt;

  assign key_wr  = reg_we_i & (reg_addr_i == ADDR_W'(OFF_SRST)) & (reg_wdata_i == DATA_W'(SRST_KEY));
  assign stat_wr = reg_we_i & (reg_addr_i == ADDR_W'(OFF_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         win_cnt <= 0;
    else if (core_rst_o) win_cnt <= win_cnt + 1;
    else                 win_cnt <= 0;
  end

  p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_o);

  p_set_needs_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0));

  p_clear_needs_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(stat_q) & ~stat_q) != '0) |-> ($past(stat_wr) || core_rst_o)));

  p_rst_from_key_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(key_wr));

  p_rst_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (stat_q == '0 && ien_q == '0 && !gie_q && !irq_o));

  p_rst_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt <= RST_CYCLES);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(core_rst_o) |-> (ien_q == '0 && !gie_q));
endmodule

bind spi_irq_regs spi_irq_regs_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .evt_i(evt_i), .irq_o(irq_o), .core_rst_o(core_rst_o),
  .stat_q(stat_q), .ien_q(ien_q), .gie_q(gie_q)
);

// File: tb/spi_irq_regs_bench.sv
module spi_irq_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 7;
  localparam int RSTC = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NSRC-1:0] evt = '0;
  logic        irq;
  logic        crst;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_regs #(.NUM_SRC(NSRC), .ADDR_W(8), .DATA_W(32), .RST_CYCLES(RSTC)) u_spi_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq), .core_rst_o(crst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); evt[i] = 1'b1;
    @(negedge clk); evt[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h1C, d); chk("R1 gie", d, 0);
    rd(8'h20, d); chk("R1 stat", d, 0);
    rd(8'h28, d); chk("R1 ien", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 core_rst", crst, 0);
    rd(8'h40, d); chk("R11 srst read", d, 0);
    rd(8'h44, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    pulse(2);
    rd(8'h20, d); chk("R2 R7 tx empty latched", d, 32'h04);
    pulse(6);
    rd(8'h20, d); chk("R7 half empty bit6", d, 32'h44);
    @(negedge clk); evt[0] = 1'b1;
    @(negedge clk);
    rd(8'h20, d); chk("R2 held level sets", d, 32'h45);
    wr(8'h20, 32'h01);
    @(negedge clk);
    rd(8'h20, d); chk("R2 held level no re-set", d, 32'h44);
    evt[0] = 1'b0;
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(8'h20, 32'h04);
    rd(8'h20, d); chk("R3 clear one bit", d, 32'h40);
    wr(8'h20, 32'h0);
    rd(8'h20, d); chk("R3 zero write keeps", d, 32'h40);
    @(negedge clk); we = 1'b1; addr = 8'h20; wdata = 32'h20; evt[5] = 1'b1;
    @(negedge clk); we = 1'b0; evt[5] = 1'b0;
    rd(8'h20, d); chk("R3 set wins over clear", d, 32'h60);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R3 clear all", d, 0);
  endtask

  task automatic t_enables;
    logic [31:0] d;
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R4 ien width", d, 32'h7F);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R5 gie bit31 only", d, 32'h8000_0000);
    wr(8'h1C, 32'h0);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_irq;
    pulse(4);
    wr(8'h1C, 32'h8000_0000);
    chk("R6 no enable no irq", irq, 0);
    wr(8'h28, 32'h40);
    chk("R6 other source enabled", irq, 0);
    wr(8'h28, 32'h10);
    chk("R6 irq raised", irq, 1);
    wr(8'h1C, 32'h7FFF_FFFF);
    chk("R6 gie clear gates", irq, 0);
    wr(8'h1C, 32'h8000_0000);
    chk("R6 irq back", irq, 1);
    wr(8'h20, 32'h10);
    chk("R6 cleared no irq", irq, 0);
    pulse(4);
  endtask

  task automatic t_badkey;
    logic [31:0] d;
    wr(8'h40, 32'h0B);
    chk("R9 no reset on bad key", crst, 0);
    rd(8'h28, d); chk("R9 ien kept", d, 32'h10);
    rd(8'h20, d); chk("R9 stat kept", d, 32'h10);
    chk("R9 irq kept", irq, 1);
  endtask

  task automatic t_sreset;
    logic [31:0] d;
    int hi;
    wr(8'h40, 32'h0A);
    hi = 0;
    chk("R8 reset starts", crst, 1);
    rd(8'h20, d); chk("R8 stat zeroed", d, 0);
    chk("R8 irq low", irq, 0);
    while (crst && hi < 20) begin
      if (hi == 0) begin
        we = 1'b1; addr = 8'h28; wdata = 32'h7F; evt[3] = 1'b1;
      end else if (hi == 1) begin
        we = 1'b0; evt[3] = 1'b0; evt[1] = 1'b1;
      end
      hi++;
      @(negedge clk);
    end
    chk("R8 window length", hi, RSTC);
    rd(8'h28, d); chk("R10 write ignored", d, 0);
    rd(8'h1C, d); chk("R8 gie zeroed", d, 0);
    @(negedge clk);
    rd(8'h20, d); chk("R10 events ignored", d, 0);
    evt[1] = 1'b0;
    pulse(1);
    rd(8'h20, d); chk("R2 works after reset", d, 32'h02);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_clear();
    t_enables();
    t_irq();
    t_badkey();
    t_sreset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule